// File: doc/BRIEF.md
# Operating-System Context Slot with Pull-and-Invalidate Read

This block is the per-thread storage for the context word that identifies which virtual processor the operating-system ring currently runs. The word names a target by a small block number and an index within that block, and carries a valid flag that says whether the slot is live. Software loads the word through a write port. A dispatcher removes a context through a "pull" read. The pull returns the word as it stood before the request and clears the valid flag in the stored copy on the same clock edge. Other stored bits are left as they are.

The pull answer comes from a three-state response machine. The states are `RSP_IDLE` (no answer pending), `RSP_HIT` (the pulled line was valid) and `RSP_MISS` (the pulled line was already invalid). A pull request moves the machine to `RSP_HIT` or `RSP_MISS`, depending on the valid flag it sees. Any cycle without a request returns it to `RSP_IDLE`. `RSP_HIT` and `RSP_MISS` can also move straight to one another when pulls come back to back. A miss still returns the data, but it raises a one-cycle error pulse and sets a sticky error flag that only reset clears. The decoded block, index and valid fields of the stored word are always visible.

Top module: `os_ctx_slot`

## Requirements
- R1: Reset sets the stored word to zero. After reset the decoded fields read zero, and `pull_vld`, `err_pulse` and `err_sticky` are low.
- R2: One cycle after `wr_en`, the stored word equals `wr_data`. The fields then decode as follows: `ctx_valid` is bit 31, `ctx_blk` is bits 22:19 and `ctx_idx` is bits 18:0.
- R3: A `pull_req` sampled at one edge yields `pull_vld` high after that edge. `pull_data` carries the word as it stood before that edge, in big-endian lane order: bits 7:0 hold word bits 31:24, bits 15:8 hold 23:16, bits 23:16 hold 15:8 and bits 31:24 hold 7:0.
- R4: After a pull with no write in the same cycle, the stored word equals its former value with bit 31 cleared. All other bits are unchanged.
- R5: A pull of a word whose bit 31 is clear still returns the data with `pull_vld`, and `err_pulse` is high in that same response cycle. A pull of a valid word leaves `err_pulse` low.
- R6: `err_sticky` rises together with the first `err_pulse` and stays high through later writes and pulls until reset.
- R7: When `wr_en` and `pull_req` fall in the same cycle, `pull_data` returns the old word and the stored word becomes `wr_data`, including its bit 31.
- R8: Two pulls on consecutive cycles of a valid word give a hit followed by a miss. The second response carries the word with bit 31 cleared.
- R9: `pull_vld` and `err_pulse` last one cycle per request. Both are low in a cycle that follows a cycle without `pull_req`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| wr_en | input | 1 | Load the context word |
| wr_data | input | 32 | New context word |
| pull_req | input | 1 | Pull-and-invalidate request |
| pull_vld | output | 1 | Pull response present |
| pull_data | output | 32 | Pre-pull word, big-endian lane order |
| err_pulse | output | 1 | One-cycle error: pulled line was invalid |
| err_sticky | output | 1 | Error seen since reset |
| ctx_valid | output | 1 | Decoded valid flag |
| ctx_blk | output | 4 | Decoded block number |
| ctx_idx | output | 19 | Decoded index |

## Verification
The pull path is swept over every block value, combined with four index and filler patterns and both valid-flag settings. Each word is written, pulled, and then pulled again at once. The first pull separates hit from miss and checks the byte lanes. The second pull shows that only bit 31 changed and that the line now misses. A write and a pull in the same cycle show that the pull keeps the old word while the write sets the new one. Idle cycles and a mid-run reset separate the one-cycle pulse from the sticky flag.

// File: rtl/os_ctx_pkg.sv
package os_ctx_pkg;
    typedef enum logic [1:0] {
        RSP_IDLE = 2'd0,
        RSP_HIT  = 2'd1,
        RSP_MISS = 2'd2
    } rsp_state_e;
endpackage

// File: rtl/ctx_word_reg.sv
module ctx_word_reg #(
    parameter int unsigned WORD_W    = 32,
    parameter int unsigned VALID_POS = 31
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [WORD_W-1:0] wr_data,
    input  logic              pull_req,
    output logic [WORD_W-1:0] word_q
);
    logic [WORD_W-1:0] word_d;

    // Write has priority over the invalidate of a pull in the same cycle.
    always_comb begin
        word_d = word_q;
        if (wr_en) begin
            word_d = wr_data;
        end else if (pull_req) begin
            word_d[VALID_POS] = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            word_q <= '0;
        end else begin
            word_q <= word_d;
        end
    end

    p_pull_clears_valid_r4: assert property (@(posedge clk) disable iff (rst)
        (pull_req && !wr_en) |=> !word_q[VALID_POS]);

    p_pull_keeps_rest_r4: assert property (@(posedge clk) disable iff (rst)
        (pull_req && !wr_en) |=>
        ((word_q | (WORD_W'(1) << VALID_POS)) == ($past(word_q) | (WORD_W'(1) << VALID_POS))));

    p_write_wins_r7: assert property (@(posedge clk) disable iff (rst)
        wr_en |=> (word_q == $past(wr_data)));
endmodule

// File: rtl/ctx_field_decode.sv
module ctx_field_decode #(
    parameter int unsigned WORD_W    = 32,
    parameter int unsigned BLK_W     = 4,
    parameter int unsigned IDX_W     = 19,
    parameter int unsigned VALID_POS = 31
) (
    input  logic [WORD_W-1:0] word,
    output logic              valid,
    output logic [BLK_W-1:0]  blk,
    output logic [IDX_W-1:0]  idx
);
    localparam int unsigned BLK_LSB = IDX_W;

    always_comb begin
        valid = word[VALID_POS];
        blk   = word[BLK_LSB +: BLK_W];
        idx   = word[0 +: IDX_W];
    end

    initial begin
        assert (BLK_LSB + BLK_W <= VALID_POS)
            else $error("block field overlaps valid bit");
    end
endmodule

// File: rtl/pull_resp_fsm.sv
module pull_resp_fsm
    import os_ctx_pkg::*;
#(
    parameter int unsigned WORD_W = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              pull_req,
    input  logic              line_valid,
    input  logic [WORD_W-1:0] snap_data,
    output logic              pull_vld,
    output logic [WORD_W-1:0] pull_data,
    output logic              err_pulse,
    output logic              err_sticky
);
    rsp_state_e state_q, state_d;
    logic [WORD_W-1:0] data_q;
    logic              sticky_q;

    always_comb begin
        state_d = RSP_IDLE;
        unique case (state_q)
            RSP_IDLE, RSP_HIT, RSP_MISS: begin
                if (pull_req) begin
                    state_d = line_valid ? RSP_HIT : RSP_MISS;
                end
            end
            default: state_d = RSP_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q  <= RSP_IDLE;
            data_q   <= '0;
            sticky_q <= 1'b0;
        end else begin
            state_q <= state_d;
            if (pull_req) begin
                data_q <= snap_data;
            end
            if (state_d == RSP_MISS) begin
                sticky_q <= 1'b1;
            end
        end
    end

    always_comb begin
        pull_vld   = 1'b0;
        err_pulse  = 1'b0;
        unique case (state_q)
            RSP_IDLE: ;
            RSP_HIT:  pull_vld = 1'b1;
            RSP_MISS: begin
                pull_vld  = 1'b1;
                err_pulse = 1'b1;
            end
            default: ;
        endcase
        pull_data  = data_q;
        err_sticky = sticky_q;
    end

    p_req_gives_vld_r3: assert property (@(posedge clk) disable iff (rst)
        pull_req |=> pull_vld);

    p_err_with_vld_r5: assert property (@(posedge clk) disable iff (rst)
        err_pulse |-> pull_vld);

    p_miss_flags_err_r5: assert property (@(posedge clk) disable iff (rst)
        (pull_req && !line_valid) |=> err_pulse);

    p_idle_after_gap_r9: assert property (@(posedge clk) disable iff (rst)
        !pull_req |=> (!pull_vld && !err_pulse));

    p_sticky_holds_r6: assert property (@(posedge clk) disable iff (rst)
        err_sticky |=> err_sticky);

    p_sticky_with_err_r6: assert property (@(posedge clk) disable iff (rst)
        err_pulse |-> err_sticky);
endmodule

// File: rtl/os_ctx_slot.sv
module os_ctx_slot #(
    parameter int unsigned WORD_W    = 32,
    parameter int unsigned BLK_W     = 4,
    parameter int unsigned IDX_W     = 19,
    parameter int unsigned VALID_POS = 31
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [WORD_W-1:0] wr_data,
    input  logic              pull_req,
    output logic              pull_vld,
    output logic [WORD_W-1:0] pull_data,
    output logic              err_pulse,
    output logic              err_sticky,
    output logic              ctx_valid,
    output logic [BLK_W-1:0]  ctx_blk,
    output logic [IDX_W-1:0]  ctx_idx
);
    localparam int unsigned NBYTES = WORD_W / 8;

    logic [WORD_W-1:0] word_q;
    logic [WORD_W-1:0] word_be;

    ctx_word_reg #(.WORD_W(WORD_W), .VALID_POS(VALID_POS)) u_word (
        .clk      (clk),
        .rst      (rst),
        .wr_en    (wr_en),
        .wr_data  (wr_data),
        .pull_req (pull_req),
        .word_q   (word_q)
    );

    ctx_field_decode #(
        .WORD_W(WORD_W), .BLK_W(BLK_W), .IDX_W(IDX_W), .VALID_POS(VALID_POS)
    ) u_dec (
        .word  (word_q),
        .valid (ctx_valid),
        .blk   (ctx_blk),
        .idx   (ctx_idx)
    );

    // Most significant byte goes to the lowest lane.
    for (genvar b = 0; b < NBYTES; b++) begin : g_lane
        assign word_be[8*b +: 8] = word_q[8*(NBYTES-1-b) +: 8];
    end

    pull_resp_fsm #(.WORD_W(WORD_W)) u_fsm (
        .clk        (clk),
        .rst        (rst),
        .pull_req   (pull_req),
        .line_valid (word_q[VALID_POS]),
        .snap_data  (word_be),
        .pull_vld   (pull_vld),
        .pull_data  (pull_data),
        .err_pulse  (err_pulse),
        .err_sticky (err_sticky)
    );

    p_rsp_old_word_r3: assert property (@(posedge clk) disable iff (rst)
        pull_req |=> (pull_data == $past(word_be)));

    p_rsp_hit_matches_r5: assert property (@(posedge clk) disable iff (rst)
        (pull_req && word_q[VALID_POS]) |=> !err_pulse);
endmodule

// File: tb/os_ctx_slot_tb_top.sv
module os_ctx_slot_tb_top;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        wr_en = 1'b0;
    logic [31:0] wr_data = '0;
    logic        pull_req = 1'b0;
    logic        pull_vld, err_pulse, err_sticky, ctx_valid;
    logic [31:0] pull_data;
    logic [3:0]  ctx_blk;
    logic [18:0] ctx_idx;

    int checks = 0;
    int fails  = 0;
    int cycles = 0;

    always #10 clk = ~clk;

    os_ctx_slot dut_i (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_data(wr_data),
        .pull_req(pull_req), .pull_vld(pull_vld), .pull_data(pull_data),
        .err_pulse(err_pulse), .err_sticky(err_sticky),
        .ctx_valid(ctx_valid), .ctx_blk(ctx_blk), .ctx_idx(ctx_idx)
    );

    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles > 100000) begin
            fails = fails + 1;
            $display("FAIL watchdog: run hung, actual %0d cycles expected < 100000", cycles);
            $display("End of test - %0d assertions evaluated, %0d failures", checks + 1, fails);
            $finish;
        end
    end

    function automatic logic [31:0] swap(input logic [31:0] w);
        return {w[7:0], w[15:8], w[23:16], w[31:24]};
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks = checks + 1;
        if (act !== exp) begin
            fails = fails + 1;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic chk_fields(input string req, input logic [31:0] w);
        chk(req, {31'd0, ctx_valid}, {31'd0, w[31]});
        chk(req, {28'd0, ctx_blk}, {28'd0, w[22:19]});
        chk(req, {13'd0, ctx_idx}, {13'd0, w[18:0]});
    endtask

    task automatic do_write(input logic [31:0] w);
        @(negedge clk); wr_en = 1'b1; wr_data = w;
        @(negedge clk); wr_en = 1'b0;
    endtask

    task automatic do_pull();
        @(negedge clk); pull_req = 1'b1;
        @(negedge clk); pull_req = 1'b0;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        chk("R1 fields", {ctx_valid, 8'd0, ctx_blk, ctx_idx}, 32'd0);
        chk("R1 flags", {29'd0, pull_vld, err_pulse, err_sticky}, 32'd0);

        for (int blk = 0; blk < 16; blk++) begin
            for (int k = 0; k < 4; k++) begin
                logic [31:0] w;
                logic [31:0] cleared;
                logic [18:0] idx;
                logic [7:0]  mid;
                idx = 19'((blk * 12345 + k * 54321) ^ (k == 3 ? 32'h7FFFF : 32'h0));
                mid = 8'((blk * 7 + k * 29) & 255);
                w = {k[0], mid, 4'(blk), idx};
                cleared = {1'b0, w[30:0]};
                do_write(w);
                chk_fields("R2 decode", w);
                // first pull: pull request sampled, then both edges back-to-back
                @(negedge clk); pull_req = 1'b1;
                @(negedge clk);
                chk("R3 vld", {31'd0, pull_vld}, 32'd1);
                chk("R3 data", pull_data, swap(w));
                chk("R5 err", {31'd0, err_pulse}, {31'd0, ~w[31]});
                chk_fields("R4 after pull", cleared);
                // second pull on the next edge
                @(negedge clk); pull_req = 1'b0;
                chk("R8 second data", pull_data, swap(cleared));
                chk("R8 second err", {30'd0, pull_vld, err_pulse}, 32'd3);
                chk("R6 sticky", {31'd0, err_sticky}, 32'd1);
                @(negedge clk);
                chk("R9 quiet", {30'd0, pull_vld, err_pulse}, 32'd0);
            end
        end

        // R7: write and pull in one cycle
        do_write(32'h80A5_1234);
        @(negedge clk); pull_req = 1'b1; wr_en = 1'b1; wr_data = 32'h8123_4567;
        @(negedge clk); pull_req = 1'b0; wr_en = 1'b0;
        chk("R7 old returned", pull_data, swap(32'h80A5_1234));
        chk("R7 no err", {31'd0, err_pulse}, 32'd0);
        chk_fields("R7 write wins", 32'h8123_4567);
        do_pull();
        chk("R7 stored new", pull_data, swap(32'h8123_4567));

        // R1/R6: reset clears sticky and word
        @(negedge clk); rst = 1'b1;
        @(negedge clk); rst = 1'b0;
        chk("R6 sticky cleared by reset", {31'd0, err_sticky}, 32'd0);
        chk("R1 word after reset", {ctx_valid, 8'd0, ctx_blk, ctx_idx}, 32'd0);
        do_write(32'hFFFF_FFFF);
        do_pull();
        chk("R6 hit leaves sticky low", {31'd0, err_sticky}, 32'd0);
        chk("R3 all-ones data", pull_data, 32'hFFFF_FFFF);
        do_pull();
        chk("R5 miss on all-but-valid", pull_data, swap(32'h7FFF_FFFF));
        chk("R6 sticky set", {31'd0, err_sticky}, 32'd1);
        do_write(32'h8000_0001);
        do_pull();
        chk("R6 sticky survives", {31'd0, err_sticky}, 32'd1);

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule